// File: doc/BRIEF.md
# Dual-Mode Serial Transmit Engine

This block sends words onto a serial data pin. It has two modes. In asynchronous mode it builds a framed character on a line that idles high. In synchronous mode it shifts bare data bits alongside a bit clock. As synchronous master it makes that clock from the baud tick. As synchronous slave it follows a clock that arrives on an input pin.

Software writes a byte-wide control register and a holding register. When the shifter is empty and transmission is allowed, the engine copies the holding word into the shifter. A status bit in the control byte shows whether the shifter is empty. An optional ninth bit, taken from the control byte, follows the data bits.

The engine also decides the direction of the data and clock pins. Both output enables drop, and any word in flight is abandoned, in two cases: the serial port is switched off, or a receive request takes the pins in synchronous mode.

Top module: `sertx_ctrl`

## Requirements
- R1: After reset the control byte reads 8'h02, the holding register is empty, the data line is 1, the bit clock is 0 and both output enables are 0.
- R2: Control byte fields: bit 7 = clock master, bit 6 = ninth-bit enable, bit 5 = transmit enable, bit 4 = synchronous select, bits 3:2 always read 0, bit 1 = shifter-empty status (read-only), bit 0 = ninth data bit. Bits 7:4 and 0 read back as written.
- R3: A word is loaded when three things hold together: the shifter is empty, transmission is active, and the holding register is full. On the load, holding-empty goes to 1 and the status bit goes to 0.
- R4: An asynchronous frame is a 0 start bit, then the data bits LSB first, then a 1 stop bit. Each bit lasts 16 baud ticks, and the line idles at 1.
- R5: With bit 6 set, the ninth data bit (bit 0 of the control byte at load time) is sent after the 8 data bits. In asynchronous mode it comes before the stop bit.
- R6: The status bit returns to 1 once the last bit of a word has completed.
- R7: In synchronous master mode the clock enable is 1. Each baud tick toggles the clock. Data changes only on a clock falling edge, and the clock rests at 0 between words.
- R8: In synchronous slave mode the clock enable is 0 while the data enable is 1. Data advances by one bit on each falling edge of the external clock, after a two-flop synchronizer.
- R9: In asynchronous mode the clock-master bit has no effect: the clock enable stays 0.
- R10: In synchronous mode, an active single or continuous receive request drops both enables one cycle later. It also aborts the transfer, so the status reads 1 and the clock reads 0. In asynchronous mode the receive requests have no effect.
- R11: Clearing the serial-port enable drops both enables one cycle later and aborts any transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| port_en | input | 1 | Serial-port enable |
| ctl_we | input | 1 | Control byte write strobe |
| ctl_wdata | input | 8 | Control byte write value |
| ctl_rdata | output | 8 | Control byte read value with status |
| hold_we | input | 1 | Holding register write strobe |
| hold_wdata | input | DW | Word to transmit |
| hold_empty | output | 1 | Holding register empty flag |
| baud_tick | input | 1 | One-cycle baud tick pulse |
| rx_single_en | input | 1 | Single-receive request |
| rx_cont_en | input | 1 | Continuous-receive request |
| ext_clk_in | input | 1 | External bit clock for slave mode |
| dat_o | output | 1 | Serial data out |
| dat_oe | output | 1 | Data pin output enable |
| clk_o | output | 1 | Bit clock out (master mode) |
| clk_oe | output | 1 | Clock pin output enable |

## Verification
The hardest state to reach is an abort in the middle of a word. It needs a word that has been loaded and partly shifted at the moment a receive request or a port disable arrives. The stimulus starts a transfer with no expected item queued, so the scoreboard stays idle. It waits until the status bit reads 0 and several ticks have gone by, then raises the override. Slave mode adds a second hard case: the bench has to produce the external clock edges itself, and only after it has seen the load.

// File: rtl/sertx_pkg.sv
package sertx_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_ASYNC, ST_SYNC} tx_state_e;

  // Control byte bit positions (software-visible layout).
  localparam int CB_MASTER = 7;
  localparam int CB_NINE   = 6;
  localparam int CB_TXEN   = 5;
  localparam int CB_SYNC   = 4;
  localparam int CB_EMPTY  = 1;
  localparam int CB_D9     = 0;

  typedef struct packed {
    logic master;
    logic nine;
    logic txen;
    logic sync;
    logic d9;
  } cfg_t;
endpackage

// File: rtl/sertx_regs.sv
module sertx_regs import sertx_pkg::*; #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ctl_we,
  input  logic [7:0]    ctl_wdata,
  input  logic          hold_we,
  input  logic [DW-1:0] hold_wdata,
  input  logic          load,
  output cfg_t          cfg,
  output logic [DW-1:0] hold_data,
  output logic          hold_empty
);
  always_ff @(posedge clk) begin
    if (rst) begin
      cfg <= '0;
    end else if (ctl_we) begin
      cfg.master <= ctl_wdata[CB_MASTER];
      cfg.nine   <= ctl_wdata[CB_NINE];
      cfg.txen   <= ctl_wdata[CB_TXEN];
      cfg.sync   <= ctl_wdata[CB_SYNC];
      cfg.d9     <= ctl_wdata[CB_D9];
    end
  end

  // Holding register; a write in the load cycle keeps the new word pending.
  always_ff @(posedge clk) begin
    if (rst) begin
      hold_data  <= '0;
      hold_empty <= 1'b1;
    end else if (hold_we) begin
      hold_data  <= hold_wdata;
      hold_empty <= 1'b0;
    end else if (load) begin
      hold_empty <= 1'b1;
    end
  end

  a_r3_load_frees_hold: assert property (@(posedge clk) disable iff (rst)
    (load && !hold_we) |=> hold_empty);
endmodule

// File: rtl/sertx_sync.sv
module sertx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic fall
);
  logic [STAGES-1:0] q;
  logic              last;

  always_ff @(posedge clk) begin
    if (rst) begin
      q    <= '0;
      last <= 1'b0;
    end else begin
      q    <= {q[STAGES-2:0], din};
      last <= q[STAGES-1];
    end
  end

  assign fall = last & ~q[STAGES-1];
endmodule

// File: rtl/sertx_shift.sv
module sertx_shift import sertx_pkg::*; #(
  parameter int DW  = 8,
  parameter int OVS = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          active,
  input  cfg_t          cfg,
  input  logic [DW-1:0] data_in,
  input  logic          hold_full,
  input  logic          baud_tick,
  input  logic          ext_fall,
  output logic          load,
  output logic          dat_o,
  output logic          clk_o,
  output logic          trmt
);
  localparam int FW = DW + 3;
  localparam int LW = $clog2(FW + 1);
  localparam int TW = $clog2(OVS);

  tx_state_e      st;
  logic [FW-1:0]  sh, frame_a, frame_s;
  logic [LW-1:0]  left;
  logic [TW-1:0]  cnt;
  logic           clk_q;
  logic           step;

  always_comb begin
    frame_a         = '1;
    frame_a[0]      = 1'b0;
    frame_a[DW:1]   = data_in;
    if (cfg.nine) frame_a[DW+1] = cfg.d9;
    frame_s         = '1;
    frame_s[DW-1:0] = data_in;
    if (cfg.nine) frame_s[DW] = cfg.d9;
  end

  assign load = (st == ST_IDLE) && active && hold_full;

  // One bit completes on this cycle.
  always_comb begin
    step = 1'b0;
    case (st)
      ST_ASYNC: step = baud_tick && (cnt == TW'(OVS - 1));
      ST_SYNC:  step = cfg.master ? (baud_tick && clk_q) : ext_fall;
      default:  step = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst || !active) begin
      st    <= ST_IDLE;
      sh    <= '1;
      left  <= '0;
      cnt   <= '0;
      clk_q <= 1'b0;
      trmt  <= 1'b1;
    end else begin
      case (st)
        ST_IDLE: begin
          if (hold_full) begin
            trmt  <= 1'b0;
            cnt   <= '0;
            clk_q <= 1'b0;
            if (cfg.sync) begin
              st   <= ST_SYNC;
              sh   <= frame_s;
              left <= cfg.nine ? LW'(DW + 1) : LW'(DW);
            end else begin
              st   <= ST_ASYNC;
              sh   <= frame_a;
              left <= cfg.nine ? LW'(DW + 3) : LW'(DW + 2);
            end
          end
        end
        default: begin
          if (st == ST_ASYNC && baud_tick) cnt <= cnt + 1'b1;
          if (st == ST_SYNC && cfg.master && baud_tick) clk_q <= ~clk_q;
          if (step) begin
            cnt  <= '0;
            sh   <= {1'b1, sh[FW-1:1]};
            left <= left - 1'b1;
            if (left == LW'(1)) begin
              st    <= ST_IDLE;
              trmt  <= 1'b1;
              clk_q <= 1'b0;
            end
          end
        end
      endcase
    end
  end

  assign dat_o = sh[0];
  assign clk_o = clk_q;

  a_r6_status_tracks_idle: assert property (@(posedge clk) disable iff (rst)
    trmt == (st == ST_IDLE));
  a_r7_clock_rests_low: assert property (@(posedge clk) disable iff (rst)
    (st == ST_IDLE) |-> !clk_q);
  a_r7_data_on_fall: assert property (@(posedge clk) disable iff (rst)
    (st == ST_SYNC && $past(st) == ST_SYNC && cfg.master && !$stable(sh[0]))
      |-> $fell(clk_q));
  a_r10_abort_to_idle: assert property (@(posedge clk) disable iff (rst)
    !active |=> (st == ST_IDLE));
endmodule

// File: rtl/sertx_ctrl.sv
module sertx_ctrl import sertx_pkg::*; #(
  parameter int DW        = 8,
  parameter int OVS       = 16,
  parameter int SYNC_STGS = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          port_en,
  input  logic          ctl_we,
  input  logic [7:0]    ctl_wdata,
  output logic [7:0]    ctl_rdata,
  input  logic          hold_we,
  input  logic [DW-1:0] hold_wdata,
  output logic          hold_empty,
  input  logic          baud_tick,
  input  logic          rx_single_en,
  input  logic          rx_cont_en,
  input  logic          ext_clk_in,
  output logic          dat_o,
  output logic          dat_oe,
  output logic          clk_o,
  output logic          clk_oe
);
  cfg_t          cfg;
  logic [DW-1:0] hold_data;
  logic          load, trmt, ext_fall, active;

  assign active = port_en && cfg.txen && !(cfg.sync && (rx_single_en || rx_cont_en));

  sertx_regs #(.DW(DW)) u_regs (
    .clk(clk), .rst(rst), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
    .hold_we(hold_we), .hold_wdata(hold_wdata), .load(load),
    .cfg(cfg), .hold_data(hold_data), .hold_empty(hold_empty)
  );

  sertx_sync #(.STAGES(SYNC_STGS)) u_sync (
    .clk(clk), .rst(rst), .din(ext_clk_in), .fall(ext_fall)
  );

  sertx_shift #(.DW(DW), .OVS(OVS)) u_shift (
    .clk(clk), .rst(rst), .active(active), .cfg(cfg), .data_in(hold_data),
    .hold_full(!hold_empty), .baud_tick(baud_tick), .ext_fall(ext_fall),
    .load(load), .dat_o(dat_o), .clk_o(clk_o), .trmt(trmt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      dat_oe <= 1'b0;
      clk_oe <= 1'b0;
    end else begin
      dat_oe <= active;
      clk_oe <= active && cfg.sync && cfg.master;
    end
  end

  always_comb begin
    ctl_rdata            = '0;
    ctl_rdata[CB_MASTER] = cfg.master;
    ctl_rdata[CB_NINE]   = cfg.nine;
    ctl_rdata[CB_TXEN]   = cfg.txen;
    ctl_rdata[CB_SYNC]   = cfg.sync;
    ctl_rdata[CB_EMPTY]  = trmt;
    ctl_rdata[CB_D9]     = cfg.d9;
  end

  a_r9_async_no_clock: assert property (@(posedge clk) disable iff (rst)
    !cfg.sync |=> !clk_oe);
  a_r8_slave_no_clock: assert property (@(posedge clk) disable iff (rst)
    (cfg.sync && !cfg.master) |=> !clk_oe);
  a_r11_port_off: assert property (@(posedge clk) disable iff (rst)
    !port_en |=> (!dat_oe && !clk_oe));
endmodule

// File: tb/sertx_ctrl_test.sv
module sertx_ctrl_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       port_en = 1'b0, ctl_we = 1'b0, hold_we = 1'b0;
  logic [7:0] ctl_wdata = '0, hold_wdata = '0, ctl_rdata;
  logic       hold_empty, baud_tick = 1'b0;
  logic       rx_single_en = 1'b0, rx_cont_en = 1'b0, ext_clk_in = 1'b0;
  logic       dat_o, dat_oe, clk_o, clk_oe;

  int nchk = 0, nerr = 0, tick_seen = 0, cyc = 0, tdiv = 0;
  int mon_mode = 0;          // 0 async, 1 sync master, 2 sync slave
  logic mon_nine = 1'b0;
  logic [8:0] exp_q[$];

  always #2 clk = ~clk;      // 250 MHz

  sertx_ctrl uut (
    .clk(clk), .rst(rst), .port_en(port_en), .ctl_we(ctl_we),
    .ctl_wdata(ctl_wdata), .ctl_rdata(ctl_rdata), .hold_we(hold_we),
    .hold_wdata(hold_wdata), .hold_empty(hold_empty), .baud_tick(baud_tick),
    .rx_single_en(rx_single_en), .rx_cont_en(rx_cont_en),
    .ext_clk_in(ext_clk_in), .dat_o(dat_o), .dat_oe(dat_oe),
    .clk_o(clk_o), .clk_oe(clk_oe)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    tdiv <= (tdiv == 3) ? 0 : tdiv + 1;
    baud_tick <= (tdiv == 3);
    if (baud_tick) tick_seen <= tick_seen + 1;
  end

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    nchk++;
    if (got !== exp) begin
      nerr++;
      $display("FAIL %s got=%0h exp=%0h", req, got, exp);
    end
  endtask

  task automatic cycles(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wctl(input logic [7:0] v);
    cycles(1);
    ctl_we = 1'b1; ctl_wdata = v;
    cycles(1);
    ctl_we = 1'b0;
    cycles(2);
  endtask

  // Driver: queue the expected word, write holding register, run the word.
  task automatic send(input logic [7:0] d, input logic d9, input logic do_push);
    int nb = mon_nine ? 9 : 8;
    if (do_push) exp_q.push_back({mon_nine ? d9 : 1'b0, d});
    cycles(1);
    hold_we = 1'b1; hold_wdata = d;
    cycles(1);
    hold_we = 1'b0;
    for (int i = 0; i < 20 && ctl_rdata[1]; i++) @(negedge clk);
    @(negedge clk);
    chk("R3 status cleared on load", ctl_rdata[1], 1'b0);
    chk("R3 holding freed on load", hold_empty, 1'b1);
    if (!do_push) return;
    if (mon_mode == 2) begin
      for (int i = 0; i < nb; i++) begin
        cycles(6); ext_clk_in = 1'b1;
        cycles(6); ext_clk_in = 1'b0;
      end
    end
    for (int i = 0; i < 6000 && !ctl_rdata[1]; i++) @(negedge clk);
    chk("R6 status set after last bit", ctl_rdata[1], 1'b1);
    for (int i = 0; i < 100 && exp_q.size() != 0; i++) @(negedge clk);
    chk("R6 scoreboard drained", exp_q.size(), 0);
  endtask

  // Monitor: collect words from the pins and compare with the queue.
  initial begin
    logic [10:0] b;
    logic [8:0]  got, exp;
    logic        pc;
    int          t0, nb;
    forever begin
      @(negedge clk);
      if (exp_q.size() != 0 && !rst) begin
        nb = mon_nine ? 9 : 8;
        got = '0;
        if (mon_mode == 0) begin
          if (dat_oe && dat_o == 1'b0) begin
            t0 = tick_seen;
            b = '0;
            for (int i = 0; i < nb + 2; i++) begin
              while (tick_seen < t0 + 8 + 16 * i) @(negedge clk);
              b[i] = dat_o;
            end
            for (int i = 0; i < nb; i++) got[i] = b[i+1];
            exp = exp_q.pop_front();
            chk("R4 start bit", b[0], 1'b0);
            chk("R4 stop bit", b[nb+1], 1'b1);
            chk(mon_nine ? "R5 nine-bit async word" : "R4 async word", got, exp);
          end
        end else begin
          for (int i = 0; i < nb; i++) begin
            do begin
              pc = (mon_mode == 1) ? clk_o : ext_clk_in;
              @(negedge clk);
            end while (!(((mon_mode == 1) ? clk_o : ext_clk_in) && !pc));
            got[i] = dat_o;
          end
          exp = exp_q.pop_front();
          chk(mon_mode == 1 ? "R7 master word" : "R8 slave word", got, exp);
        end
      end
    end
  end

  initial begin
    while (cyc < 150000) @(posedge clk);
    nerr++; nchk++;
    $display("FAIL watchdog expired got=%0d exp=<150000", cyc);
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    cycles(5);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 ctl reset", ctl_rdata, 8'h02);
    chk("R1 hold empty", hold_empty, 1'b1);
    chk("R1 line idle", dat_o, 1'b1);
    chk("R1 data enable", dat_oe, 1'b0);
    chk("R1 clock", clk_o, 1'b0);
    chk("R1 clock enable", clk_oe, 1'b0);

    wctl(8'hFF);
    chk("R2 reserved zero, status read-only", ctl_rdata, 8'hF3);
    wctl(8'h00);
    chk("R2 readback", ctl_rdata, 8'h02);

    port_en = 1'b1;
    mon_mode = 0; mon_nine = 1'b0;
    wctl(8'h20);
    chk("R4 data enable async", dat_oe, 1'b1);
    send(8'hA5, 1'b0, 1'b1);
    chk("R4 idle high", dat_o, 1'b1);
    send(8'h3C, 1'b0, 1'b1);

    wctl(8'hA0);
    chk("R9 no clock in async", clk_oe, 1'b0);
    send(8'h5A, 1'b0, 1'b1);
    rx_cont_en = 1'b1; rx_single_en = 1'b1;
    cycles(2);
    chk("R10 receive ignored in async", dat_oe, 1'b1);
    rx_cont_en = 1'b0; rx_single_en = 1'b0;

    mon_nine = 1'b1;
    wctl(8'h61);
    send(8'h81, 1'b1, 1'b1);
    wctl(8'h60);
    send(8'hFF, 1'b0, 1'b1);

    mon_mode = 1; mon_nine = 1'b0;
    wctl(8'hB0);
    chk("R7 clock enable master", clk_oe, 1'b1);
    send(8'hC3, 1'b0, 1'b1);
    cycles(4);
    chk("R7 clock rests low", clk_o, 1'b0);
    mon_nine = 1'b1;
    wctl(8'hF1);
    send(8'h12, 1'b1, 1'b1);

    mon_mode = 2; mon_nine = 1'b0;
    wctl(8'h30);
    chk("R8 slave clock enable", clk_oe, 1'b0);
    chk("R8 slave data enable", dat_oe, 1'b1);
    send(8'h96, 1'b0, 1'b1);

    mon_mode = 1;
    wctl(8'hB0);
    send(8'hFF, 1'b0, 1'b0);
    cycles(20);
    rx_single_en = 1'b1;
    cycles(2);
    @(negedge clk);
    chk("R10 data enable dropped", dat_oe, 1'b0);
    chk("R10 clock enable dropped", clk_oe, 1'b0);
    chk("R10 aborted status", ctl_rdata[1], 1'b1);
    chk("R10 clock low", clk_o, 1'b0);
    rx_single_en = 1'b0;

    mon_mode = 0;
    wctl(8'h20);
    send(8'h00, 1'b0, 1'b0);
    cycles(30);
    port_en = 1'b0;
    cycles(2);
    @(negedge clk);
    chk("R11 data enable dropped", dat_oe, 1'b0);
    chk("R11 aborted status", ctl_rdata[1], 1'b1);
    chk("R11 line idle", dat_o, 1'b1);

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule